// File: doc/BRIEF.md
# Watchdog and interrupt pin controller

This block combines a 6-bit watchdog with the logic that drives one interrupt pin. The watchdog counts down once per 32 Hz tick from a programmable timeout. When the count runs out, it raises an expiry event. The expiry event, an alarm event and a power-fail event each set their own sticky flag. Any of them can also drive the shared interrupt pin if its enable is set. The pin can be configured in three ways:

- as an active-high push-pull output or as an active-low open-drain output;
- to emit a pulse of fixed length or to hold a level until software reads the flags;
- to be gated by backup-power state.

A host reaches three registers through a simple synchronous bus with separate write and read strobes:

- **Watchdog register (address 0).** Bits 5:0 hold the timeout, bit 6 is the timeout write mask, and bit 7 is the reload strobe.
- **Interrupt control register (address 1).** Bit 5 enables power-fail, bit 4 enables the watchdog, bit 3 enables the alarm, bit 2 selects pulse mode, bit 1 selects active-high push-pull, and bit 0 is the alarm backup enable.
- **Flags register (address 2).** Bit 0 is the watchdog flag, bit 1 the alarm flag and bit 2 the power-fail flag. Reading this register clears it.

Read data is registered and appears one cycle after the read strobe.

The watchdog FSM has three states:

- `WD_OFF`: disabled.
- `WD_PEND`: a new timeout has been written and waits for the next tick.
- `WD_COUNT`: counting.

Its transitions follow this priority:

- A strobe goes to `WD_COUNT` with the current timeout, or to `WD_OFF` if the timeout is 0.
- A timeout write goes to `WD_PEND`.
- A tick in `WD_PEND` goes to `WD_COUNT`, or to `WD_OFF` for timeout 0.
- A tick in `WD_COUNT` at count 1 expires and reloads.

The pin FSM has three states:

- `PIN_IDLE`: released.
- `PIN_PULSE`: timed pulse.
- `PIN_HOLD`: level held.

Its transitions follow this priority:

- An enabled event enters `PIN_PULSE` (restarting the timer) or `PIN_HOLD`, according to the mode bit.
- Otherwise a flags read returns to `PIN_IDLE`.
- Otherwise `PIN_PULSE` returns to `PIN_IDLE` when its timer is spent.

Top module: `wdt_irq_ctrl`

## Requirements
- R1: After reset the interrupt control register reads 24h, the watchdog register reads the timeout parameter `TO_RESET` with mask 0, the flags read 0, and the pin is released (`irq_oe_o`=0, `irq_o`=0).
- R2: In the watchdog register, a write with bit 6 = 1 leaves the timeout unchanged, bit 6 reads back as last written, and bit 7 always reads 0.
- R3: A write with bit 6 = 0 stores bits 5:0 as the timeout. The next tick loads it, and expiry follows after exactly that many further ticks.
- R4: When the count runs out, flags bit 0 is set and the counter reloads from the timeout. A timeout of 0 never expires. At reset the counter starts from `TO_RESET`.
- R5: A write with bit 7 = 1 reloads the counter at once from the timeout, so expiry comes a full timeout of ticks after the strobe.
- R6: Each event sets its flag (bit 0 watchdog, bit 1 alarm, bit 2 power-fail) whether or not it is enabled. A read of address 2 returns the flags and clears them. An event in the same cycle as that read stays set.
- R7: The interrupt control bits are laid out as follows: bit 5 power-fail enable, bit 4 watchdog enable, bit 3 alarm enable, bit 2 pulse mode, bit 1 active-high push-pull, bit 0 alarm backup enable. Bits 7:6 read 0.
- R8: In pulse mode an enabled event makes the pin active for exactly `PULSE_CYC` cycles, starting at the next clock edge. A flags read ends the pulse, and a further enabled event restarts it.
- R9: In level mode an enabled event keeps the pin active until the flags are read.
- R10: With bit 1 = 1 the pin is push-pull: `irq_oe_o` equals not backup and `irq_o` is the active state. With bit 1 = 0 it is open-drain: `irq_o` is 0 and `irq_oe_o` is the active state.
- R11: While `backup_i` is 1, the watchdog never drives the pin, the alarm drives it only when bit 0 is 1, and power-fail drives it whenever enabled.
- R12: Read data updates on the clock edge of the read strobe and holds until the next read. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | One-cycle 32 Hz watchdog tick |
| alarm_evt_i | input | 1 | One-cycle alarm match event |
| pfail_evt_i | input | 1 | One-cycle power-fail event |
| backup_i | input | 1 | High while running from backup power |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | TO_W+2 | Write data |
| reg_rdata_o | output | TO_W+2 | Registered read data |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with `PULSE_CYC` = 6 and `TO_RESET` = 2. The short pulse makes the exact pulse length, the cut-short read and the release edge visible within a few cycles. The nonzero reset timeout makes the watchdog run straight out of reset, so the power-up load and expiry are checked without any prior write. The tick is an input driven by the bench, so each timeout, strobe, pending load and disable case is reached within tens of cycles. A behavioural model in the bench predicts the pin and read data on every clock. Directed checks pin down the collision of a read with an event and the backup gating of each source.

// File: rtl/wdt_irq_pkg.sv
package wdt_irq_pkg;

    localparam int ADDR_W = 2;
    localparam int ICTL_W = 6;
    localparam int NSRC   = 3;

    localparam logic [ADDR_W-1:0] ADDR_WDOG = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ICTL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

    // source positions inside the flags register
    localparam int SRC_WD = 0;
    localparam int SRC_AL = 1;
    localparam int SRC_PF = 2;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_PEND  = 2'd1,
        WD_COUNT = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        PIN_IDLE  = 2'd0,
        PIN_PULSE = 2'd1,
        PIN_HOLD  = 2'd2
    } pin_state_e;

    // interrupt control register, bit 5 down to bit 0
    typedef struct packed {
        logic pf_en;
        logic wd_en;
        logic al_en;
        logic pulse;
        logic pol_high;
        logic al_bk;
    } ictl_t;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_irq_pkg::*;
#(
    parameter int TO_W     = 6,
    parameter int TO_RESET = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            strobe_i,
    input  logic            wr_to_i,
    input  logic [TO_W-1:0] to_wdata_i,
    output logic [TO_W-1:0] to_o,
    output logic            expire_o
);

    localparam logic [TO_W-1:0] TO_INIT = TO_W'(TO_RESET);
    localparam logic [TO_W-1:0] ONE     = TO_W'(1);

    wd_state_e       state_q, state_d;
    logic [TO_W-1:0] cnt_q, cnt_d;
    logic [TO_W-1:0] to_q, to_next;

    assign to_next = wr_to_i ? to_wdata_i : to_q;
    assign to_o    = to_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= (TO_INIT != '0) ? WD_COUNT : WD_OFF;
            cnt_q   <= TO_INIT;
            to_q    <= TO_INIT;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            to_q    <= to_next;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (strobe_i) begin
            cnt_d   = to_next;
            state_d = (to_next != '0) ? WD_COUNT : WD_OFF;
        end else if (wr_to_i) begin
            state_d = WD_PEND;
        end else if (tick_i) begin
            unique case (state_q)
                WD_OFF: begin
                    state_d = WD_OFF;
                end
                WD_PEND: begin
                    cnt_d   = to_q;
                    state_d = (to_q != '0) ? WD_COUNT : WD_OFF;
                end
                WD_COUNT: begin
                    if (cnt_q == ONE) begin
                        expire_o = 1'b1;
                        cnt_d    = to_q;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: begin
                    state_d = WD_OFF;
                end
            endcase
        end
    end

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_COUNT) |-> (cnt_q != '0 && cnt_q <= to_q));

    // R4
    expire_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> tick_i);

    // R5
    strobe_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !wr_to_i && to_q != '0) |=> (state_q == WD_COUNT && cnt_q == $past(to_q)));

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import wdt_irq_pkg::*;
#(
    parameter int PULSE_CYC = 6553600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic pulse_mode_i,
    input  logic clear_i,
    input  logic pol_high_i,
    input  logic backup_i,
    output logic pin_o,
    output logic pin_oe_o
);

    localparam int PW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);
    localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYC - 1);

    pin_state_e    state_q, state_d;
    logic [PW-1:0] cnt_q, cnt_d;
    logic          active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fire_i) begin
            if (pulse_mode_i) begin
                state_d = PIN_PULSE;
                cnt_d   = PULSE_LOAD;
            end else begin
                state_d = PIN_HOLD;
            end
        end else if (clear_i) begin
            state_d = PIN_IDLE;
        end else begin
            unique case (state_q)
                PIN_IDLE: state_d = PIN_IDLE;
                PIN_PULSE: begin
                    if (cnt_q == '0) state_d = PIN_IDLE;
                    else             cnt_d   = cnt_q - PW'(1);
                end
                PIN_HOLD: state_d = PIN_HOLD;
                default:  state_d = PIN_IDLE;
            endcase
        end
    end

    // output process: drive type chosen by the polarity bit
    always_comb begin
        active = (state_q != PIN_IDLE);
        if (pol_high_i) begin
            pin_oe_o = !backup_i;
            pin_o    = active;
        end else begin
            pin_oe_o = active;
            pin_o    = 1'b0;
        end
    end

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_HOLD && !clear_i) |=> (state_q != PIN_IDLE));

    // R8
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !fire_i) |=> (state_q == PIN_IDLE));

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && pulse_mode_i) |=> (state_q == PIN_PULSE && cnt_q == PULSE_LOAD));

    // R10
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_high_i) |-> (!pin_o));

endmodule

// File: rtl/int_regs.sv
module int_regs
    import wdt_irq_pkg::*;
#(
    parameter int          TO_W       = 6,
    parameter logic [5:0]  ICTL_RESET = 6'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [TO_W+1:0]   wdata_i,
    input  logic [TO_W-1:0]   to_i,
    input  logic              wd_exp_i,
    input  logic              alarm_i,
    input  logic              pfail_i,
    input  logic              backup_i,
    output logic              strobe_o,
    output logic              wr_to_o,
    output logic [TO_W-1:0]   to_wdata_o,
    output logic              fire_o,
    output logic              pulse_mode_o,
    output logic              pol_high_o,
    output logic              clear_o,
    output logic [TO_W+1:0]   rdata_o
);

    localparam int DATA_W   = TO_W + 2;
    localparam int MASK_BIT = TO_W;
    localparam int STRB_BIT = TO_W + 1;

    ictl_t             ictl_q;
    logic              mask_q;
    logic [NSRC-1:0]   ev, en, allow, flag_q;
    logic [DATA_W-1:0] rd_val;
    logic              wr_wdog, wr_ictl;

    assign wr_wdog    = wr_i && (addr_i == ADDR_WDOG);
    assign wr_ictl    = wr_i && (addr_i == ADDR_ICTL);
    assign strobe_o   = wr_wdog && wdata_i[STRB_BIT];
    assign wr_to_o    = wr_wdog && !wdata_i[MASK_BIT];
    assign to_wdata_o = wdata_i[TO_W-1:0];
    assign clear_o    = rd_i && (addr_i == ADDR_FLAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ictl_q <= ictl_t'(ICTL_RESET);
            mask_q <= 1'b0;
        end else begin
            if (wr_ictl) ictl_q <= ictl_t'(wdata_i[ICTL_W-1:0]);
            if (wr_wdog) mask_q <= wdata_i[MASK_BIT];
        end
    end

    // event, enable and backup gate vectors in flag order
    always_comb begin
        ev[SRC_WD]    = wd_exp_i;
        ev[SRC_AL]    = alarm_i;
        ev[SRC_PF]    = pfail_i;
        en[SRC_WD]    = ictl_q.wd_en;
        en[SRC_AL]    = ictl_q.al_en;
        en[SRC_PF]    = ictl_q.pf_en;
        allow[SRC_WD] = !backup_i;
        allow[SRC_AL] = !backup_i || ictl_q.al_bk;
        allow[SRC_PF] = 1'b1;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q && !clear_o) || ev[i];
        end
        assign flag_q[i] = bit_q;

        // R6
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flag_q[i]);
    end

    assign fire_o       = |(ev & en & allow);
    assign pulse_mode_o = ictl_q.pulse;
    assign pol_high_o   = ictl_q.pol_high;

    always_comb begin
        unique case (addr_i)
            ADDR_WDOG: rd_val = {1'b0, mask_q, to_i};
            ADDR_ICTL: rd_val = DATA_W'(ictl_q);
            ADDR_FLAG: rd_val = DATA_W'(flag_q);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_val;
    end

    // R2
    strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == ADDR_WDOG) |=> !rdata_o[STRB_BIT]);

    // R11
    backup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_i && !pfail_i && !ictl_q.al_bk) |-> !fire_o);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i) |=> $stable(rdata_o));

endmodule

// File: rtl/wdt_irq_ctrl.sv
module wdt_irq_ctrl
    import wdt_irq_pkg::*;
#(
    parameter int         TO_W       = 6,
    parameter int         TO_RESET   = 0,
    parameter logic [5:0] ICTL_RESET = 6'h24,
    parameter int         PULSE_CYC  = 6553600
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            alarm_evt_i,
    input  logic            pfail_evt_i,
    input  logic            backup_i,
    input  logic            reg_wr_i,
    input  logic            reg_rd_i,
    input  logic [1:0]      reg_addr_i,
    input  logic [TO_W+1:0] reg_wdata_i,
    output logic [TO_W+1:0] reg_rdata_o,
    output logic            irq_o,
    output logic            irq_oe_o
);

    logic            strobe, wr_to, wd_exp, fire, pulse_mode, pol_high, clear;
    logic [TO_W-1:0] to_val, to_wdata;

    wdt_counter #(
        .TO_W     (TO_W),
        .TO_RESET (TO_RESET)
    ) i_wdt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .strobe_i   (strobe),
        .wr_to_i    (wr_to),
        .to_wdata_i (to_wdata),
        .to_o       (to_val),
        .expire_o   (wd_exp)
    );

    int_regs #(
        .TO_W       (TO_W),
        .ICTL_RESET (ICTL_RESET)
    ) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr_i),
        .rd_i         (reg_rd_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .to_i         (to_val),
        .wd_exp_i     (wd_exp),
        .alarm_i      (alarm_evt_i),
        .pfail_i      (pfail_evt_i),
        .backup_i     (backup_i),
        .strobe_o     (strobe),
        .wr_to_o      (wr_to),
        .to_wdata_o   (to_wdata),
        .fire_o       (fire),
        .pulse_mode_o (pulse_mode),
        .pol_high_o   (pol_high),
        .clear_o      (clear),
        .rdata_o      (reg_rdata_o)
    );

    irq_pin_ctrl #(
        .PULSE_CYC (PULSE_CYC)
    ) i_pin (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire_i       (fire),
        .pulse_mode_i (pulse_mode),
        .clear_i      (clear),
        .pol_high_i   (pol_high),
        .backup_i     (backup_i),
        .pin_o        (irq_o),
        .pin_oe_o     (irq_oe_o)
    );

    // R10
    pp_backup_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_high && backup_i) |-> !irq_oe_o);

endmodule

// File: tb/test_wdt_irq_ctrl.sv
module test_wdt_irq_ctrl;

    localparam int PULSE  = 6;
    localparam int TO_RST = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, alarm = 1'b0, pfail = 1'b0, backup = 1'b0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, irq_oe;
    int         n_chk = 0, n_err = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    wdt_irq_ctrl #(
        .TO_W (6), .TO_RESET (TO_RST), .ICTL_RESET (6'h24), .PULSE_CYC (PULSE)
    ) i_wdt_irq_ctrl (
        .clk (clk), .rst_n (rst_n), .tick_i (tick), .alarm_evt_i (alarm),
        .pfail_evt_i (pfail), .backup_i (backup), .reg_wr_i (wr), .reg_rd_i (rd),
        .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
        .irq_o (irq), .irq_oe_o (irq_oe)
    );

    // behavioural reference model
    logic [5:0] m_to, m_icr;
    logic       m_mask, m_run, m_pend;
    int         m_cnt, m_pin, m_left;   // m_pin: 0 idle, 1 pulse, 2 hold
    logic [2:0] m_flags;
    logic [7:0] m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_to = 6'(TO_RST); m_cnt = TO_RST; m_run = (TO_RST != 0); m_pend = 1'b0;
            m_icr = 6'h24; m_mask = 1'b0; m_flags = 3'b0; m_pin = 0; m_left = 0;
            m_rdata = 8'h00;
        end else begin
            logic strobe, wrto, expd, fire, clr;
            logic [5:0] new_to;
            logic [2:0] ev, en, allow;
            strobe = wr && addr == 2'd0 && wdata[7];
            wrto   = wr && addr == 2'd0 && !wdata[6];
            new_to = wrto ? wdata[5:0] : m_to;
            expd   = 1'b0;
            if (strobe) begin
                m_pend = 1'b0; m_run = (new_to != 0); m_cnt = int'(new_to);
            end else if (wrto) begin
                m_pend = 1'b1;
            end else if (tick) begin
                if (m_pend) begin
                    m_pend = 1'b0; m_run = (m_to != 0); m_cnt = int'(m_to);
                end else if (m_run) begin
                    if (m_cnt == 1) begin expd = 1'b1; m_cnt = int'(m_to); end
                    else m_cnt = m_cnt - 1;
                end
            end
            if (rd) begin
                case (addr)
                    2'd0: m_rdata = {1'b0, m_mask, m_to};
                    2'd1: m_rdata = {2'b0, m_icr};
                    2'd2: m_rdata = {5'b0, m_flags};
                    default: m_rdata = 8'h00;
                endcase
            end
            ev    = {pfail, alarm, expd};
            en    = {m_icr[5], m_icr[3], m_icr[4]};
            allow = {1'b1, !backup || m_icr[0], !backup};
            fire  = |(ev & en & allow);
            clr   = rd && addr == 2'd2;
            m_flags = (clr ? 3'b0 : m_flags) | ev;
            if (fire) begin
                if (m_icr[2]) begin m_pin = 1; m_left = PULSE - 1; end
                else m_pin = 2;
            end else if (clr) begin
                m_pin = 0;
            end else if (m_pin == 1) begin
                if (m_left == 0) m_pin = 0; else m_left = m_left - 1;
            end
            m_to = new_to;
            if (wr && addr == 2'd0) m_mask = wdata[6];
            if (wr && addr == 2'd1) m_icr = wdata[5:0];
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic act, exp_o, exp_oe;
            act    = (m_pin != 0);
            exp_oe = m_icr[1] ? !backup : act;
            exp_o  = m_icr[1] ? act : 1'b0;
            n_chk++;
            if (irq !== exp_o || irq_oe !== exp_oe) begin
                n_err++;
                $display("FAIL R10 pin model: actual o=%b oe=%b expected o=%b oe=%b", irq, irq_oe, exp_o, exp_oe);
            end
            n_chk++;
            if (rdata !== m_rdata) begin
                n_err++;
                $display("FAIL R12 read data model: actual %0h expected %0h", rdata, m_rdata);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic adv();
        @(posedge clk); #2;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d; adv(); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        rd = 1'b1; addr = a; adv(); rd = 1'b0; d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin tick = 1'b1; adv(); tick = 1'b0; end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) adv();
    endtask

    task automatic pf_evt();
        pfail = 1'b1; adv(); pfail = 1'b0;
    endtask

    task automatic al_evt();
        alarm = 1'b1; adv(); alarm = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run hung, actual running expected done");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        adv();
        // R1 reset state
        chk("R1 oe", {7'b0, irq_oe}, 8'h00);
        chk("R1 pin", {7'b0, irq}, 8'h00);
        rd_reg(2'd1, v); chk("R1 ictl", v, 8'h24);
        rd_reg(2'd0, v); chk("R1 wdog", v, 8'h02);
        rd_reg(2'd2, v); chk("R1 flags", v, 8'h00);
        rd_reg(2'd3, v); chk("R12 addr3", v, 8'h00);

        // R4 power-up load, flag set while disabled (R6)
        ticks(2);
        chk("R4 disabled wd no pin", {7'b0, irq_oe}, 8'h00);
        rd_reg(2'd2, v); chk("R4 wd flag", v, 8'h01);
        rd_reg(2'd2, v); chk("R6 read clears", v, 8'h00);

        // R8 pulse, open-drain default
        pf_evt();
        chk("R8 pulse start oe", {7'b0, irq_oe}, 8'h01);
        chk("R10 open-drain low", {7'b0, irq}, 8'h00);
        idle(PULSE - 1);
        chk("R8 pulse last cycle", {7'b0, irq_oe}, 8'h01);
        idle(1);
        chk("R8 pulse ended", {7'b0, irq_oe}, 8'h00);
        rd_reg(2'd2, v); chk("R6 pf flag", v, 8'h04);

        // R8 pulse cut short by read
        pf_evt(); idle(1);
        chk("R8 pulse running", {7'b0, irq_oe}, 8'h01);
        rd_reg(2'd2, v); chk("R8 read flags", v, 8'h04);
        chk("R8 cut short", {7'b0, irq_oe}, 8'h00);

        // R3 new timeout, R9 level, R10 push-pull
        wr_reg(2'd1, 8'h12);
        chk("R10 push-pull idle oe", {7'b0, irq_oe}, 8'h01);
        chk("R10 push-pull idle low", {7'b0, irq}, 8'h00);
        wr_reg(2'd0, 8'h03);
        ticks(3);
        chk("R3 not yet expired", {7'b0, irq}, 8'h00);
        ticks(1);
        chk("R3 expired on fourth tick", {7'b0, irq}, 8'h01);
        idle(10);
        chk("R9 level held", {7'b0, irq}, 8'h01);
        rd_reg(2'd2, v); chk("R9 flags", v, 8'h01);
        chk("R9 released by read", {7'b0, irq}, 8'h00);

        // R2 mask, R5 strobe
        wr_reg(2'd0, 8'h45);
        rd_reg(2'd0, v); chk("R2 masked timeout", v, 8'h43);
        ticks(2);
        wr_reg(2'd0, 8'hC0);
        ticks(2);
        chk("R5 strobe delayed expiry", {7'b0, irq}, 8'h00);
        ticks(1);
        chk("R5 expiry after strobe", {7'b0, irq}, 8'h01);
        rd_reg(2'd0, v); chk("R2 strobe reads 0", v, 8'h43);
        rd_reg(2'd2, v); chk("R5 flags", v, 8'h01);

        // R4 timeout 0 disables
        wr_reg(2'd0, 8'h00);
        ticks(6);
        rd_reg(2'd2, v); chk("R4 disabled no flag", v, 8'h00);
        rd_reg(2'd0, v); chk("R3 zero timeout stored", v, 8'h00);

        // R11 backup gating, R7 fields
        wr_reg(2'd1, 8'h0A);
        backup = 1'b1; adv();
        chk("R10 push-pull released in backup", {7'b0, irq_oe}, 8'h00);
        wr_reg(2'd1, 8'h08);
        al_evt();
        chk("R11 alarm gated", {7'b0, irq_oe}, 8'h00);
        rd_reg(2'd2, v); chk("R6 alarm flag", v, 8'h02);
        wr_reg(2'd1, 8'h09);
        al_evt();
        chk("R11 alarm backup enable", {7'b0, irq_oe}, 8'h01);
        rd_reg(2'd2, v); chk("R7 alarm flag", v, 8'h02);
        chk("R9 release", {7'b0, irq_oe}, 8'h00);
        wr_reg(2'd1, 8'h20);
        pf_evt();
        chk("R11 pf in backup", {7'b0, irq_oe}, 8'h01);
        rd_reg(2'd2, v); chk("R11 pf flag", v, 8'h04);
        wr_reg(2'd1, 8'h10);
        wr_reg(2'd0, 8'h01);
        ticks(2);
        chk("R11 wd gated", {7'b0, irq_oe}, 8'h00);
        rd_reg(2'd2, v); chk("R11 wd flag", v, 8'h01);
        backup = 1'b0;

        // R6 read in same cycle as event
        wr_reg(2'd1, 8'h20);
        rd = 1'b1; addr = 2'd2; pfail = 1'b1; adv(); rd = 1'b0; pfail = 1'b0;
        chk("R6 collision read value", rdata, 8'h00);
        chk("R6 collision pin", {7'b0, irq_oe}, 8'h01);
        rd_reg(2'd2, v); chk("R6 event kept", v, 8'h04);
        chk("R6 pin released", {7'b0, irq_oe}, 8'h00);
        rd_reg(2'd1, v); chk("R7 ictl readback", v, 8'h20);

        idle(2);
        finish_run();
    end

endmodule